// File: doc/BRIEF.md
# Per-Lane Buffer Address Generator

This block turns one vector buffer memory operation into per-lane byte addresses. A start pulse captures a 128-bit resource descriptor, a scalar offset, an immediate offset, the per-lane index and offset vectors, and an execute mask. The block then walks the lanes in order, one lane per clock. For each lane it either produces a 48-bit address or flags the lane as out of bounds.

Addresses come in two forms. The linear form is base plus offset plus stride times index. The swizzled form interleaves elements across a power-of-two group of indices. Each form has its own bounds rule. Out-of-bounds lanes are collected in a mask that is kept apart from the execute mask. The load/store unit downstream uses that mask to write zero to load destinations and to drop stores. It issues memory requests only for lanes in the request mask.

The descriptor is laid out as follows: base [47:0], stride [61:48], swizzle enable [62], record count [94:63], data format [98:95], element-size select [100:99], index-stride select [102:101], add-lane-number enable [103]. Bits [127:104] are ignored.

Top module: `buf_lane_addr_gen`

## Requirements
- R1: The effective stride is {data format, stride} (data format << 14 plus stride) when add-lane-number is set, and the 14-bit stride field alone otherwise. The descriptor is decoded with the bit layout given above.
- R2: The lane index is the lane's slice of `vidx` plus the lane number when add-lane-number is set. The lane offset is the lane's slice of `voff` plus `ioff`. Lane i occupies bits [32i+31:32i] of `vidx` and `voff`.
- R3: With swizzle disabled, the address is base + scalar offset + offset + stride*index.
- R4: With swizzle enabled, let G = 8 << index-stride select and E = 2 << element-size select. The address is base + scalar offset + ((index/G*stride + offset/E*E)*G + (index mod G)*E + offset mod E). The address form depends on the swizzle bit alone.
- R5: When the effective stride is zero or swizzle is disabled, a lane is out of bounds if offset + stride*index + scalar offset >= record count. This is computed without overflow, so a scalar offset above the record count puts every lane out of bounds.
- R6: When the effective stride is non-zero and swizzle is enabled, a lane is out of bounds if index >= record count or offset >= effective stride.
- R7: An out-of-bounds active lane is emitted with `lane_oob`=1 and `lane_addr`=0, and its bit is set in `oob_mask`.
- R8: A lane whose execute bit is clear takes its slot with `lane_valid`=0, `lane_oob`=0, and sets no bit in `oob_mask`.
- R9: Lane k appears on the outputs k+1 cycles after the start edge, carrying `lane_id`=k. `done` is high for exactly one cycle, LANES+1 cycles after the start edge.
- R10: `req_mask` equals the execute mask AND NOT `oob_mask` from the `done` cycle until the next start. A start clears both masks, and the two masks never share a set bit.
- R11: While reset is asserted, and in the cycle after it, every output is zero and any walk in progress is abandoned.
- R12: Address arithmetic is 48 bits wide and wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures operands and begins a lane walk |
| desc | input | 128 | Resource descriptor |
| soff | input | 32 | Scalar offset |
| ioff | input | IOFF_W | Immediate instruction offset |
| vidx | input | LANES*IDX_W | Per-lane index vector |
| voff | input | LANES*OFF_W | Per-lane offset vector |
| exec | input | LANES | Execute mask |
| lane_valid | output | 1 | Active lane on the outputs this cycle |
| lane_id | output | LW | Lane number of the current slot |
| lane_addr | output | 48 | Byte address, zero when out of bounds |
| lane_oob | output | 1 | Current lane is out of bounds |
| done | output | 1 | One-cycle pulse after the final lane |
| oob_mask | output | LANES | Out-of-bounds lanes of the current operation |
| req_mask | output | LANES | Lanes that should issue a memory request |

## Verification
A corrupted lane counter shows up on the very next lane slot. `lane_id` goes out of sequence, the wrong execute bit gates `lane_valid`, and `done` comes early or late. A wrong operand or bounds decision appears within the lane's own slot as a wrong address or `lane_oob` bit. It then persists in `oob_mask` and in `req_mask` at `done`. Stale mask state from an earlier operation becomes visible at the first slot of the next operation, because the masks should read zero after start.

// File: rtl/bla_pkg.sv
package bla_pkg;
  localparam int AW       = 48;
  localparam int SOFF_W   = 32;
  localparam int STRIDE_W = 14;
  localparam int FMT_W    = 4;
  localparam int NREC_W   = 32;
  localparam int DESC_IN_W = 128;

  // decoded descriptor, MSB first
  typedef struct packed {
    logic                add_tid;
    logic [1:0]          idx_sel;
    logic [1:0]          elem_sel;
    logic [FMT_W-1:0]    fmt;
    logic [NREC_W-1:0]   nrec;
    logic                swz;
    logic [STRIDE_W-1:0] stride;
    logic [AW-1:0]       base;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/bla_lane_seq.sv
module bla_lane_seq #(
  parameter int LANES = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [LW-1:0] cnt,
  output logic          last
);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

  assign last = busy && (cnt == LAST_LANE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST_LANE) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bla_lane_math.sv
module bla_lane_math
  import bla_pkg::*;
#(
  parameter int IDX_W  = 32,
  parameter int OFF_W  = 32,
  parameter int IOFF_W = 12,
  parameter int LW     = 3
) (
  input  desc_t             dsc,
  input  logic [SOFF_W-1:0] soff,
  input  logic [IOFF_W-1:0] ioff,
  input  logic [IDX_W-1:0]  raw_idx,
  input  logic [OFF_W-1:0]  raw_off,
  input  logic [LW-1:0]     lane,
  output logic [AW-1:0]     addr,
  output logic              oob
);
  localparam int IW = IDX_W + 1;
  localparam int OW = ((OFF_W > IOFF_W) ? OFF_W : IOFF_W) + 1;
  localparam int SW = STRIDE_W + FMT_W;
  localparam int KW = SW + ((IW > OW) ? IW : OW) + 2;

  logic [IW-1:0] idx;
  logic [OW-1:0] off;
  logic [SW-1:0] stride;
  logic [KW-1:0] lin_sum;
  logic          oob_lin, oob_swz;
  logic [2:0]    ish, esh;
  logic [AW-1:0] idx_a, off_a, str_a;
  logic [AW-1:0] idx_hi, idx_lo, off_lo, off_hs;
  logic [AW-1:0] swz_term, lin_term;

  always_comb begin
    idx    = IW'(raw_idx) + (dsc.add_tid ? IW'(lane) : IW'(0));
    off    = OW'(raw_off) + OW'(ioff);
    stride = dsc.add_tid ? {dsc.fmt, dsc.stride} : SW'(dsc.stride);

    // bounds, full width so nothing overflows
    lin_sum = KW'(off) + KW'(stride) * KW'(idx) + KW'(soff);
    oob_lin = lin_sum >= KW'(dsc.nrec);
    oob_swz = (KW'(idx) >= KW'(dsc.nrec)) || (KW'(off) >= KW'(stride));
    oob     = ((stride == '0) || !dsc.swz) ? oob_lin : oob_swz;

    // power-of-two group and element sizes as shift amounts
    ish = {1'b0, dsc.idx_sel} + 3'd3;
    esh = {1'b0, dsc.elem_sel} + 3'd1;

    idx_a  = AW'(idx);
    off_a  = AW'(off);
    str_a  = AW'(stride);
    idx_lo = idx_a & ((AW'(1) << ish) - AW'(1));
    idx_hi = idx_a >> ish;
    off_lo = off_a & ((AW'(1) << esh) - AW'(1));
    off_hs = off_a - off_lo;

    swz_term = ((idx_hi * str_a + off_hs) << ish) + (idx_lo << esh) + off_lo;
    lin_term = off_a + str_a * idx_a;
    addr     = dsc.base + AW'(soff) + (dsc.swz ? swz_term : lin_term);
  end
endmodule

// File: rtl/buf_lane_addr_gen.sv
module buf_lane_addr_gen
  import bla_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int IDX_W  = 32,
  parameter int OFF_W  = 32,
  parameter int IOFF_W = 12,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DESC_IN_W-1:0]   desc,
  input  logic [SOFF_W-1:0]      soff,
  input  logic [IOFF_W-1:0]      ioff,
  input  logic [LANES*IDX_W-1:0] vidx,
  input  logic [LANES*OFF_W-1:0] voff,
  input  logic [LANES-1:0]       exec,
  output logic                   lane_valid,
  output logic [LW-1:0]          lane_id,
  output logic [AW-1:0]          lane_addr,
  output logic                   lane_oob,
  output logic                   done,
  output logic [LANES-1:0]       oob_mask,
  output logic [LANES-1:0]       req_mask
);
  // upper descriptor bits carry nothing for this block
  logic unused_desc_hi;
  assign unused_desc_hi = ^desc[DESC_IN_W-1:DESC_W];

  desc_t             dsc_q;
  logic [SOFF_W-1:0] soff_q;
  logic [IOFF_W-1:0] ioff_q;
  logic [LANES-1:0]  exec_q;
  logic [IDX_W-1:0]  idx_q [LANES];
  logic [OFF_W-1:0]  off_q [LANES];

  logic          busy, last, last_out;
  logic [LW-1:0] cnt;
  logic [AW-1:0] m_addr;
  logic          m_oob;

  bla_lane_seq #(.LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .cnt(cnt), .last(last)
  );

  bla_lane_math #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .IOFF_W(IOFF_W), .LW(LW)
  ) u_math (
    .dsc(dsc_q), .soff(soff_q), .ioff(ioff_q),
    .raw_idx(idx_q[cnt]), .raw_off(off_q[cnt]), .lane(cnt),
    .addr(m_addr), .oob(m_oob)
  );

  // operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      dsc_q  <= '0;
      soff_q <= '0;
      ioff_q <= '0;
      exec_q <= '0;
      for (int i = 0; i < LANES; i++) begin
        idx_q[i] <= '0;
        off_q[i] <= '0;
      end
    end else if (start) begin
      dsc_q  <= desc_t'(desc[DESC_W-1:0]);
      soff_q <= soff;
      ioff_q <= ioff;
      exec_q <= exec;
      for (int i = 0; i < LANES; i++) begin
        idx_q[i] <= vidx[i*IDX_W +: IDX_W];
        off_q[i] <= voff[i*OFF_W +: OFF_W];
      end
    end
  end

  // lane output stage and masks
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_valid <= 1'b0;
      lane_id    <= '0;
      lane_addr  <= '0;
      lane_oob   <= 1'b0;
      last_out   <= 1'b0;
      done       <= 1'b0;
      oob_mask   <= '0;
      req_mask   <= '0;
    end else begin
      lane_valid <= 1'b0;
      lane_addr  <= '0;
      lane_oob   <= 1'b0;
      last_out   <= 1'b0;
      done       <= last_out;
      if (last_out) req_mask <= exec_q & ~oob_mask;
      if (start) begin
        oob_mask <= '0;
        req_mask <= '0;
      end else if (busy) begin
        lane_id    <= cnt;
        lane_valid <= exec_q[cnt];
        last_out   <= last;
        if (exec_q[cnt]) begin
          lane_oob      <= m_oob;
          lane_addr     <= m_oob ? '0 : m_addr;
          oob_mask[cnt] <= m_oob;
        end
      end
    end
  end
endmodule

// File: rtl/bla_chk.sv
module bla_chk #(
  parameter int LANES = 8,
  parameter int LW    = 3,
  parameter int AW    = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             lane_valid,
  input logic [LW-1:0]    lane_id,
  input logic [AW-1:0]    lane_addr,
  input logic             lane_oob,
  input logic             done,
  input logic [LANES-1:0] oob_mask,
  input logic [LANES-1:0] req_mask
);
  assert_oob_is_valid_R7: assert property (@(posedge clk) disable iff (rst)
    lane_oob |-> lane_valid);

  assert_oob_addr_zero_R7: assert property (@(posedge clk) disable iff (rst)
    lane_oob |-> (lane_addr == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(lane_id) == LW'(LANES - 1)));

  assert_no_lane_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !lane_valid);

  assert_masks_disjoint_R10: assert property (@(posedge clk) disable iff (rst)
    (req_mask & oob_mask) == '0);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> (oob_mask == '0 && req_mask == '0));
endmodule

bind buf_lane_addr_gen bla_chk #(.LANES(LANES), .LW(LW), .AW(bla_pkg::AW)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .lane_valid(lane_valid), .lane_id(lane_id), .lane_addr(lane_addr),
  .lane_oob(lane_oob), .done(done), .oob_mask(oob_mask), .req_mask(req_mask)
);

// File: tb/buf_lane_addr_gen_test.sv
module buf_lane_addr_gen_test;
  localparam int L = 4;

  typedef struct packed {
    logic [47:0]       base;
    logic [13:0]       stride;
    logic              swz;
    logic [31:0]       nrec;
    logic [3:0]        fmt;
    logic [1:0]        es;
    logic [1:0]        is;
    logic              tid;
    logic [31:0]       soff;
    logic [11:0]       ioff;
    logic [3:0]        exec;
    logic [3:0][31:0]  idx;
    logic [3:0][31:0]  off;
    logic [3:0]        exp_oob;
  } vec_t;

  // lane vectors are written lane3 .. lane0
  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    // 0: linear, immediate offset (R3 R2)
    '{48'h1000, 14'd16, 1'b0, 32'd1000, 4'd0, 2'd0, 2'd0, 1'b0, 32'd4, 12'd8, 4'hF,
      {32'd3, 32'd2, 32'd1, 32'd0}, {32'd12, 32'd8, 32'd4, 32'd0}, 4'b0000},
    // 1: linear bound edge, lane3 hits record count exactly (R5)
    '{48'h1000, 14'd16, 1'b0, 32'd64, 4'd0, 2'd0, 2'd0, 1'b0, 32'd0, 12'd0, 4'hF,
      {32'd3, 32'd2, 32'd1, 32'd0}, {32'd16, 32'd15, 32'd0, 32'd0}, 4'b1000},
    // 2: add lane number, format into stride, lanes 1 and 3 masked (R1 R8)
    '{48'h2000, 14'd4, 1'b0, 32'hFFFF_FFFF, 4'd1, 2'd0, 2'd0, 1'b1, 32'd0, 12'd0, 4'b0101,
      {32'd0, 32'd0, 32'd0, 32'd0}, {32'd0, 32'd0, 32'd0, 32'd0}, 4'b0000},
    // 3: swizzle, index and offset bounds (R4 R6)
    '{48'h4000, 14'd64, 1'b1, 32'd20, 4'd0, 2'd1, 2'd0, 1'b0, 32'd16, 12'd0, 4'hF,
      {32'd5, 32'd20, 32'd9, 32'd3}, {32'd64, 32'd0, 32'd6, 32'd5}, 4'b1100},
    // 4: swizzle on but stride zero uses the linear bound (R5)
    '{48'h8000, 14'd0, 1'b1, 32'd10, 4'd0, 2'd0, 2'd0, 1'b0, 32'd3, 12'd0, 4'hF,
      {32'd0, 32'd0, 32'd0, 32'd0}, {32'd100, 32'd0, 32'd7, 32'd6}, 4'b1010},
    // 5: scalar offset above record count, every lane out (R5)
    '{48'h0, 14'd0, 1'b0, 32'd2, 4'd0, 2'd0, 2'd0, 1'b0, 32'd5, 12'd0, 4'hF,
      {32'd0, 32'd0, 32'd0, 32'd0}, {32'd0, 32'd0, 32'd0, 32'd0}, 4'b1111},
    // 6: address wraps at 48 bits (R12)
    '{48'hFFFF_FFFF_FFF0, 14'd0, 1'b0, 32'hFFFF_FFFF, 4'd0, 2'd0, 2'd0, 1'b0, 32'h20, 12'd0, 4'hF,
      {32'd0, 32'd0, 32'd0, 32'd0}, {32'hC, 32'd8, 32'd4, 32'd0}, 4'b0000},
    // 7: swizzle with large groups and lane number added (R4 R2)
    '{48'h10000, 14'd100, 1'b1, 32'd100, 4'd0, 2'd3, 2'd2, 1'b1, 32'd0, 12'd0, 4'hF,
      {32'd40, 32'd33, 32'd1, 32'd0}, {32'd17, 32'd99, 32'd16, 32'd3}, 4'b0000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [127:0]      desc = '0;
  logic [31:0]       soff = '0;
  logic [11:0]       ioff = '0;
  logic [L*32-1:0]   vidx = '0;
  logic [L*32-1:0]   voff = '0;
  logic [L-1:0]      exec = '0;
  logic              lane_valid, lane_oob, done;
  logic [1:0]        lane_id;
  logic [47:0]       lane_addr;
  logic [L-1:0]      oob_mask, req_mask;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  buf_lane_addr_gen #(.LANES(L), .IDX_W(32), .OFF_W(32), .IOFF_W(12)) uut (
    .clk(clk), .rst(rst), .start(start), .desc(desc), .soff(soff), .ioff(ioff),
    .vidx(vidx), .voff(voff), .exec(exec),
    .lane_valid(lane_valid), .lane_id(lane_id), .lane_addr(lane_addr),
    .lane_oob(lane_oob), .done(done), .oob_mask(oob_mask), .req_mask(req_mask)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // address per the formulas, using divide and modulo
  function automatic logic [47:0] model(input vec_t v, input int ln);
    longint unsigned idx, off, str, g, e, r;
    idx = longint'(v.idx[ln]) + (v.tid ? longint'(ln) : 64'd0);
    off = longint'(v.off[ln]) + longint'(v.ioff);
    str = v.tid ? longint'(v.fmt) * 16384 + longint'(v.stride) : longint'(v.stride);
    if (v.swz) begin
      g = 64'd8 << v.is;
      e = 64'd2 << v.es;
      r = ((idx / g) * str + (off / e) * e) * g + (idx % g) * e + (off % e);
    end else begin
      r = off + str * idx;
    end
    return 48'(longint'(v.base) + longint'(v.soff) + r);
  endfunction

  task automatic drive(input vec_t v);
    desc  = {24'h0, v.tid, v.is, v.es, v.fmt, v.nrec, v.swz, v.stride, v.base};
    soff  = v.soff;
    ioff  = v.ioff;
    vidx  = v.idx;
    voff  = v.off;
    exec  = v.exec;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    string amode, bmode;
    amode = v.swz ? "R4" : "R3";
    bmode = (v.swz && (v.stride != 0 || (v.tid && v.fmt != 0))) ? "R6" : "R5";
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(oob_mask == '0 && req_mask == '0, "R10", {tag, " masks cleared by start"},
        {oob_mask, req_mask}, 0);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      chk(lane_valid == v.exec[k] && !done, "R8", $sformatf("%s lane%0d valid", tag, k),
          {done, lane_valid}, v.exec[k]);
      if (v.exec[k]) begin
        chk(lane_id == 2'(k), "R9", $sformatf("%s lane%0d id", tag, k), lane_id, k);
        chk(lane_oob == v.exp_oob[k], bmode, $sformatf("%s lane%0d oob", tag, k),
            lane_oob, v.exp_oob[k]);
        if (v.exp_oob[k])
          chk(lane_addr == '0, "R7", $sformatf("%s lane%0d addr", tag, k), lane_addr, 0);
        else
          chk(lane_addr == model(v, k), amode, $sformatf("%s lane%0d addr", tag, k),
              lane_addr, model(v, k));
      end else begin
        chk(lane_oob == 1'b0, "R8", $sformatf("%s lane%0d skipped oob", tag, k), lane_oob, 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R9", {tag, " done"}, done, 1);
    chk(oob_mask == (v.exp_oob & v.exec), "R7", {tag, " oob_mask"}, oob_mask, v.exp_oob & v.exec);
    chk(req_mask == (v.exec & ~v.exp_oob), "R10", {tag, " req_mask"}, req_mask, v.exec & ~v.exp_oob);
    @(negedge clk);
    chk(done == 1'b0, "R9", {tag, " done single"}, done, 0);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    vec_t v;
    bit seen_done;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!lane_valid && !lane_oob && !done && lane_addr == '0 && lane_id == '0
        && oob_mask == '0 && req_mask == '0, "R11", "reset outputs",
        {lane_valid, lane_oob, done, oob_mask, req_mask}, 0);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) run_vec(TBL[n], $sformatf("V%0d", n));

    // R10: all-out operation then an idle one, no stale mask
    run_vec(TBL[5], "all-out");
    v = TBL[5];
    v.exec = 4'b0000;
    v.exp_oob = 4'b0000;
    run_vec(v, "empty-exec");

    // R11: reset in the middle of a walk
    @(negedge clk);
    drive(TBL[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!lane_valid && !done && oob_mask == '0 && req_mask == '0 && lane_addr == '0,
        "R11", "mid-walk reset", {lane_valid, done, oob_mask}, 0);
    rst = 1'b0;
    seen_done = 1'b0;
    for (int k = 0; k < L + 3; k++) begin
      @(negedge clk);
      if (done || lane_valid) seen_done = 1'b1;
    end
    chk(!seen_done, "R11", "walk abandoned after reset", seen_done, 0);

    // R10: restart clears masks after a walk with out-of-bounds lanes
    run_vec(TBL[3], "restart");
    finish_run();
  end
endmodule